// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss by walking in-memory page tables. A request carries a 32-bit virtual address, a context number, a store flag and the context table pointer. The walker reads the context table entry for that context. It then follows table-pointer descriptors through up to three levels of tables, indexed by virtual address bits 31:24, 23:18 and 17:12. It stops at the first leaf or at the first unusable descriptor. Reads go through a memory read port that never has more than one read in flight.

A successful walk reports the leaf entry, the level where the leaf was found, and the 36-bit physical address built from that leaf. A leaf at level 1 maps 16 MB and a leaf at level 2 maps 256 KB. Before it reports, the walker writes the leaf back with its referenced flag set. A store also sets the modified flag. If those flags are already set, no write is made. A failed walk reports a fault code, the level that was reached and the faulting virtual address.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `rd_req`, `wr_req` and `done` are all low, and stay low while no request is accepted.
- R2: The first read of a walk is at physical address `{ctp, 8'h00} + 4*ctx`.
- R3: A descriptor whose bits 1:0 equal 1 is a table pointer. The next read is at `{desc[31:4], 8'h00} + 4*index`, where the index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: `rd_req` is a one-cycle pulse. A new `rd_req` never appears before `rd_valid` has returned the previous read.
- R5: A leaf (bits 1:0 equal 2) found in a level-3 table gives `level`=3 and `pa = {pte[31:8], va[11:0]}`, with `done` high for exactly one cycle.
- R6: A leaf in a level-1 table gives `level`=1 and `pa = {pte[31:20], va[23:0]}`. A leaf in a level-2 table gives `level`=2 and `pa = {pte[31:14], va[17:0]}`.
- R7: A descriptor with type 0 ends the walk with `fault`=1, `fault_code`=1, `level` equal to the level of the table read (0 for the context table), and `fault_addr` equal to the request address.
- R8: A descriptor with type 3 ends the walk with `fault`=1 and `fault_code`=2 at the level reached.
- R9: A leaf in the context table, or a table pointer in a level-3 table, ends the walk with `fault_code`=3 at that level.
- R10: On success, when an update is needed, `wr_req` stays high until `wr_ack`. The write goes to the address the leaf was read from. Its data is the leaf with bit 5 (referenced) set, and also bit 6 (modified) when the access is a store. The reported `pte` equals that data.
- R11: No write is made when bit 5 is already set and either the access is a load or bit 6 is also set.
- R12: A `req_valid` that arrives while `busy` is high is ignored, and the running walk completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | CTX_W | Context number |
| req_store | input | 1 | Access is a store |
| ctp | input | 28 | Context table pointer, address bits 35:8 |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 36 | Read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | 36 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Walk failed |
| fault_code | output | 2 | 1 invalid, 2 reserved, 3 type not allowed at level |
| level | output | 2 | Level of leaf or of fault |
| fault_addr | output | 32 | Virtual address of the walk |
| pte | output | 32 | Leaf entry after update |
| pa | output | 36 | Physical address |

## Verification
The checker assumes that memory returns `rd_valid` only for a read it was asked for, and that `wr_ack` arrives only while `wr_req` is high. The single-read and write-hold properties depend on these two conditions. The bench memory keeps to them: it answers each read after a fixed delay of two cycles, and it acknowledges a write exactly once, in the cycle after it sees the request. The table contents cover every descriptor type at every level. Repeated walks over the same leaf check that the update skip follows the flags stored by the earlier write.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int CTX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             req_store,
  input  logic [27:0]      ctp,
  output logic             busy,
  output logic             rd_req,
  output logic [35:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             wr_req,
  output logic [35:0]      wr_addr,
  output logic [31:0]      wr_data,
  input  logic             wr_ack,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_code,
  output logic [1:0]       level,
  output logic [31:0]      fault_addr,
  output logic [31:0]      pte,
  output logic [35:0]      pa
);
  localparam logic [1:0] T_INV = 2'd0, T_PTD = 2'd1, T_PTE = 2'd2;
  localparam logic [1:0] FC_INV = 2'd1, FC_RSV = 2'd2, FC_BAD = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CTX, S_L1, S_L2, S_L3, S_UPD, S_DONE} st_t;

  st_t              state, nxt_tbl;
  logic [31:0]      va;
  logic [CTX_W-1:0] ctx;
  logic             st;
  logic [27:0]      ctp_q;
  logic [35:0]      base, leaf_addr, cur_addr;
  logic             pend, fetch, need;
  logic [1:0]       cur_lvl, lvl_q, fcode_q;
  logic [31:0]      pte_q;
  logic             fault_q;

  always_comb begin
    cur_addr = '0;
    cur_lvl  = 2'd0;
    nxt_tbl  = S_DONE;
    case (state)
      S_CTX: begin cur_addr = {ctp_q, 8'h00} + 36'({ctx, 2'b00});  cur_lvl = 2'd0; nxt_tbl = S_L1; end
      S_L1:  begin cur_addr = base + 36'({va[31:24], 2'b00});      cur_lvl = 2'd1; nxt_tbl = S_L2; end
      S_L2:  begin cur_addr = base + 36'({va[23:18], 2'b00});      cur_lvl = 2'd2; nxt_tbl = S_L3; end
      S_L3:  begin cur_addr = base + 36'({va[17:12], 2'b00});      cur_lvl = 2'd3; nxt_tbl = S_DONE; end
      default: ;
    endcase
  end

  assign fetch   = (state == S_CTX) || (state == S_L1) || (state == S_L2) || (state == S_L3);
  assign rd_req  = fetch && !pend;
  assign rd_addr = cur_addr;
  assign need    = !pte_q[5] || (st && !pte_q[6]);
  assign wr_req  = (state == S_UPD) && need;
  assign wr_addr = leaf_addr;
  assign wr_data = pte_q | 32'h20 | (st ? 32'h40 : 32'h0);
  assign busy    = state != S_IDLE;
  assign done    = state == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va        <= '0;
      ctx       <= '0;
      st        <= 1'b0;
      ctp_q     <= '0;
      base      <= '0;
      leaf_addr <= '0;
      pend      <= 1'b0;
      pte_q     <= '0;
      lvl_q     <= '0;
      fault_q   <= 1'b0;
      fcode_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va      <= req_vaddr;
          ctx     <= req_ctx;
          st      <= req_store;
          ctp_q   <= ctp;
          fault_q <= 1'b0;
          fcode_q <= '0;
          lvl_q   <= '0;
          pte_q   <= '0;
          state   <= S_CTX;
        end
        S_CTX, S_L1, S_L2, S_L3: begin
          if (rd_req) pend <= 1'b1;
          if (pend && rd_valid) begin
            pend  <= 1'b0;
            lvl_q <= cur_lvl;
            case (rd_data[1:0])
              T_INV: begin fault_q <= 1'b1; fcode_q <= FC_INV; state <= S_DONE; end
              T_PTD: begin
                if (cur_lvl == 2'd3) begin
                  fault_q <= 1'b1; fcode_q <= FC_BAD; state <= S_DONE;
                end else begin
                  base  <= {rd_data[31:4], 8'h00};
                  state <= nxt_tbl;
                end
              end
              T_PTE: begin
                if (cur_lvl == 2'd0) begin
                  fault_q <= 1'b1; fcode_q <= FC_BAD; state <= S_DONE;
                end else begin
                  pte_q     <= rd_data;
                  leaf_addr <= cur_addr;
                  state     <= S_UPD;
                end
              end
              default: begin fault_q <= 1'b1; fcode_q <= FC_RSV; state <= S_DONE; end
            endcase
          end
        end
        S_UPD: if (!need || wr_ack) begin
          pte_q <= wr_data;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fault      = fault_q;
  assign fault_code = fcode_q;
  assign level      = lvl_q;
  assign fault_addr = va;
  assign pte        = pte_q;

  always_comb begin
    case (lvl_q)
      2'd1:    pa = {pte_q[31:20], va[23:0]};
      2'd2:    pa = {pte_q[31:14], va[17:0]};
      default: pa = {pte_q[31:8], va[11:0]};
    endcase
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        wr_req,
  input logic        wr_ack,
  input logic [35:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code,
  input logic [1:0]  level
);
  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outst <= 1'b0;
    else if (rd_req)   outst <= 1'b1;
    else if (rd_valid) outst <= 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req && !done));

  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outst);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_leaf_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (level != 2'd0));

  assert_fault_coded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code != 2'd0));

  assert_ref_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_data[5]);

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_valid(rd_valid),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .fault(fault), .fault_code(fault_code), .level(level)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [15:0] req_ctx = '0;
  logic [27:0] ctp = '0;
  logic        busy, rd_req, rd_valid = 1'b0, wr_req, wr_ack = 1'b0, done, fault;
  logic [35:0] rd_addr, wr_addr, pa;
  logic [31:0] rd_data = '0, wr_data, fault_addr, pte;
  logic [1:0]  fault_code, level;

  ptw_walker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [logic [35:0]];
  logic [35:0] exp_rd [$];
  int          rd_wait = 0, wr_cnt = 0;
  logic        rd_out = 1'b0;
  logic [35:0] rd_pend, last_wa;
  logic [31:0] last_wd;

  function automatic logic [31:0] rdm(logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model and per-clock read comparison
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    rd_valid = 1'b0;
    if (rst_n && rd_req) begin
      chk(!rd_out, "R4 read while pending", rd_out, 0);
      if (exp_rd.size() == 0) chk(0, "R3 unexpected read", rd_addr, 0);
      else begin
        logic [35:0] e;
        e = exp_rd.pop_front();
        chk(rd_addr == e, "R2/R3 read address", rd_addr, e);
      end
      rd_out = 1'b1; rd_pend = rd_addr; rd_wait = 2;
    end else if (rd_wait > 0) begin
      rd_wait--;
      if (rd_wait == 0) begin rd_valid = 1'b1; rd_data = rdm(rd_pend); rd_out = 1'b0; end
    end
    if (wr_req && !wr_ack) begin
      mem[wr_addr] = wr_data; last_wa = wr_addr; last_wd = wr_data; wr_cnt++;
      wr_ack = 1'b1;
    end else wr_ack = 1'b0;
  end

  function automatic logic [31:0] ptd(logic [35:0] b);
    return {b[35:8], 4'h1};
  endfunction

  task automatic walk(logic [31:0] va, logic [15:0] cx, bit store, bit poke, string tag);
    logic [35:0] b, a, la, epa;
    logic [31:0] d, epte;
    int lv; bit f, ewr; logic [1:0] fc;
    int w0, n;
    // reference walk
    b = {ctp, 8'h00}; a = b + 36'(cx) * 4; lv = 0; f = 0; fc = 0; epte = 0; la = 0;
    exp_rd.push_back(a);
    forever begin
      d = rdm(a);
      if (d[1:0] == 2'd0) begin f = 1; fc = 1; break; end
      if (d[1:0] == 2'd3) begin f = 1; fc = 2; break; end
      if (d[1:0] == 2'd2) begin
        if (lv == 0) begin f = 1; fc = 3; end
        else begin epte = d; la = a; end
        break;
      end
      if (lv == 3) begin f = 1; fc = 3; break; end
      b = {d[31:4], 8'h00}; lv++;
      case (lv)
        1: a = b + 36'(va[31:24]) * 4;
        2: a = b + 36'(va[23:18]) * 4;
        default: a = b + 36'(va[17:12]) * 4;
      endcase
      exp_rd.push_back(a);
    end
    ewr = !f && (!epte[5] || (store && !epte[6]));
    epte = epte | 32'h20 | (store ? 32'h40 : 32'h0);
    case (lv)
      1: epa = {epte[31:20], va[23:0]};
      2: epa = {epte[31:14], va[17:0]};
      default: epa = {epte[31:8], va[11:0]};
    endcase
    w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctx = cx; req_store = store;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (poke && n == 2) begin req_valid = 1'b1; req_vaddr = ~va; req_ctx = cx + 1; req_store = !store; end
      else req_valid = 1'b0;
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    chk(done, {tag, " done seen"}, done, 1);
    chk(fault == f, {tag, " fault"}, fault, f);
    chk(level == 2'(lv), {tag, " level"}, level, lv);
    chk(exp_rd.size() == 0, {tag, " all reads made"}, exp_rd.size(), 0);
    if (f) begin
      chk(fault_code == fc, {tag, " fault code"}, fault_code, fc);
      chk(fault_addr == va, {tag, " fault addr"}, fault_addr, va);
    end else begin
      chk(pa == epa, {tag, " pa"}, pa, epa);
      chk(pte == epte, {tag, " pte"}, pte, epte);
    end
    chk((wr_cnt - w0) == (ewr ? 1 : 0), {tag, " write count"}, wr_cnt - w0, ewr);
    if (ewr) begin
      chk(last_wa == la, {tag, " write addr"}, last_wa, la);
      chk(last_wd == epte, {tag, " write data"}, last_wd, epte);
    end
    exp_rd.delete();
    @(negedge clk);
    chk(!done && !busy, {tag, " done one cycle"}, {done, busy}, 0);
  endtask

  localparam logic [35:0] CT = 36'h0_0100_0000, T1 = 36'h0_0200_0000,
                          T2 = 36'h0_0300_0000, T3 = 36'h0_0400_0000,
                          U2 = 36'h0_0500_0000, U3 = 36'h0_0600_0000;

  initial begin
    ctp = CT[35:8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req && !wr_req && !done, "R1 reset idle", {busy, rd_req, wr_req, done}, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req, "R1 stays idle", {busy, rd_req}, 0);

    // context 5: full tree
    mem[CT + 5*4]            = ptd(T1);
    mem[T1 + 36'h12*4]       = ptd(T2);
    mem[T2 + 36'h0D*4]       = ptd(T3);
    mem[T3 + 36'h05*4]       = 32'hABCDEF8E;            // leaf, ref/mod clear
    walk(32'h12345678, 16'd5, 0, 0, "R5 L3 load R10");
    walk(32'h12345678, 16'd5, 0, 0, "R11 repeat load");
    walk(32'h12345678, 16'd5, 1, 0, "R10 store sets mod");
    walk(32'h12345678, 16'd5, 1, 0, "R11 repeat store");
    // R6: level-1 leaf, level-2 leaf
    mem[T1 + 36'h7F*4]       = 32'h5A500082;
    walk(32'h7F123456, 16'd5, 1, 0, "R6 L1 leaf");
    mem[T1 + 36'h20*4]       = ptd(U2);
    mem[U2 + 36'h3F*4]       = 32'h9876C0E6;            // ref+mod already set
    walk(32'h20FC1234, 16'd5, 1, 0, "R6 L2 leaf R11");
    // R7: invalid at level 1, at context
    walk(32'h44000000, 16'd5, 0, 0, "R7 invalid L1");
    walk(32'h12345678, 16'd9, 0, 0, "R7 invalid ctx");
    // R8: reserved at level 2
    mem[T2 + 36'h01*4]       = 32'h00000013;
    walk(32'h12040000, 16'd5, 0, 0, "R8 reserved L2");
    // R9: leaf in context table, pointer at level 3
    mem[CT + 10*4]           = 32'h12345602;
    walk(32'h12345678, 16'd10, 0, 0, "R9 ctx leaf");
    mem[T2 + 36'h02*4]       = ptd(U3);
    mem[U3 + 36'h00*4]       = ptd(T3);
    walk(32'h12080000, 16'd5, 0, 0, "R9 ptd at L3");
    // R12: request while busy ignored
    mem[T3 + 36'h06*4]       = 32'h11223302;
    walk(32'h12346000, 16'd5, 0, 1, "R12 busy request");
    repeat (6) @(negedge clk);
    chk(!busy && !rd_req, "R12 no stray walk", {busy, rd_req}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule